// File: doc/BRIEF.md
# Programming-Mode Entry Detector

This block sits between the external reset pin and the core. Once the external reset is released, it holds the core in reset for a fixed stretch of core clock cycles. During that stretch it watches an asynchronous mode-select pin. A rising edge is counted only after a synchroniser, and the first counted edge opens a bounded cycle window.

When the stretch ends, the block makes one decision. The core leaves reset into the serial programming boot path only if two things hold: the window caught exactly the target number of edges, and the serial data pin reads low. Otherwise the core leaves reset into normal execution.

The decision appears as a programming-mode flag and as the reset vector the core fetches first. Both hold until the external reset is asserted again. The select pin idles low, so a board with nothing attached always boots normally.

Top module: `prog_entry_detect`

## Requirements
- R1: While `pin_rst` is high, `core_rst` is 1, `prog_mode` is 0 and `reset_vector` is the user vector 16'hFFFE.
- R2: After `pin_rst` goes low, `core_rst` stays 1 for exactly 4096 rising clock edges and is 0 after the 4096th.
- R3: If exactly 33 select-pin rising edges arrive within the window during the reset stretch, and the data pin is low, `prog_mode` becomes 1 in the same cycle that `core_rst` falls.
- R4: If 32 or 34 edges arrive in the window, or none or only one, `prog_mode` stays 0.
- R5: The window opens on the first counted edge. An edge at a cycle offset of 255 after the first edge is counted. An edge at offset 256 is not counted.
- R6: If the synchronised data pin is high when the reset stretch ends, `prog_mode` stays 0 even with exactly 33 edges in the window.
- R7: Once `core_rst` is 0, `reset_vector` is 16'hFE00 (the boot ROM entry) when `prog_mode` is 1, and 16'hFFFE when it is 0.
- R8: After `core_rst` falls, select-pin edges and data-pin changes have no effect on `prog_mode` or `reset_vector` until `pin_rst` is asserted again. Edges that arrive after the reset stretch has ended are not counted.
- R9: Asserting `pin_rst` during the reset stretch discards the edges counted so far and restarts the 4096-cycle stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pin_rst | input | 1 | External reset, active high, synchronous |
| sel_pin | input | 1 | Mode-select pin, asynchronous, idles low |
| sdata_pin | input | 1 | Serial data pin, asynchronous |
| core_rst | output | 1 | Internal reset to the core, active high |
| prog_mode | output | 1 | 1 when the serial programming path was chosen |
| reset_vector | output | 16 | First fetch address for the core |

## Verification
The hardest cases to reach from the ports are the two edges of the window: the 33rd edge landing on the last counted cycle, and the same edge landing one cycle later. The stimulus reaches them with a burst shaper. It sends 32 edges at a short fixed spacing and then holds back the final edge by a chosen gap, so that the final edge falls at offset 255 or at offset 256 from the first edge.

A second hard case is a burst that straddles the end of the reset stretch. The stimulus starts that burst a few cycles before release, so only part of it can count. A third is an external reset asserted in the middle of a burst, followed by a fresh burst whose count is meaningful only if the earlier edges were discarded.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;

    localparam int unsigned      DEF_RESET_CYCLES = 4096;
    localparam int unsigned      DEF_WINDOW       = 256;
    localparam int unsigned      DEF_EDGE_TARGET  = 33;
    localparam int unsigned      DEF_SYNC_STAGES  = 2;
    localparam logic [15:0]      DEF_BOOT_VEC     = 16'hFE00;
    localparam logic [15:0]      DEF_USER_VEC     = 16'hFFFE;

    typedef enum logic [1:0] {
        WIN_IDLE,
        WIN_OPEN,
        WIN_SHUT
    } win_state_e;

    typedef enum logic {
        PH_COUNT,
        PH_RUN
    } phase_state_e;

    typedef struct packed {
        logic        entry;
        logic [15:0] vec;
    } boot_choice_t;

    function automatic boot_choice_t pick_boot(
        input logic        burst_ok,
        input logic        data_low,
        input logic [15:0] boot_vec,
        input logic [15:0] user_vec
    );
        boot_choice_t c;
        c.entry = burst_ok & data_low;
        c.vec   = c.entry ? boot_vec : user_vec;
        return c;
    endfunction

endpackage

// File: rtl/pe_pin_sync.sv
module pe_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic sync
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign sync = chain[STAGES-1];
endmodule

// File: rtl/pe_edge_window.sv
module pe_edge_window
    import prog_entry_pkg::*;
#(
    parameter int unsigned WINDOW      = DEF_WINDOW,
    parameter int unsigned EDGE_TARGET = DEF_EDGE_TARGET
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic level,
    output logic hit
);
    localparam int unsigned WW      = $clog2(WINDOW);
    localparam int unsigned CW      = $clog2(EDGE_TARGET + 2);
    localparam int unsigned CNT_SAT = EDGE_TARGET + 1;

    win_state_e    state;
    logic          prev;
    logic [WW-1:0] wcnt;
    logic [CW-1:0] cnt;
    logic          rise;

    assign rise = level & ~prev;
    assign hit  = (cnt == CW'(EDGE_TARGET));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            state <= WIN_IDLE;
            wcnt  <= '0;
            cnt   <= '0;
        end else begin
            prev <= level;
            case (state)
                WIN_IDLE: begin
                    if (enable && rise) begin
                        state <= WIN_OPEN;
                        cnt   <= CW'(1);
                        wcnt  <= WW'(1);
                    end
                end
                WIN_OPEN: begin
                    if (!enable) begin
                        state <= WIN_SHUT;
                    end else begin
                        if (rise && cnt != CW'(CNT_SAT))
                            cnt <= cnt + CW'(1);
                        if (wcnt == WW'(WINDOW - 1))
                            state <= WIN_SHUT;
                        else
                            wcnt <= wcnt + WW'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pe_phase_timer.sv
module pe_phase_timer
    import prog_entry_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = DEF_RESET_CYCLES
) (
    input  logic clk,
    input  logic rst,
    output logic counting,
    output logic last
);
    localparam int unsigned PW = $clog2(RESET_CYCLES);

    phase_state_e  state;
    logic [PW-1:0] cnt;

    assign counting = (state == PH_COUNT);
    assign last     = counting && (cnt == PW'(RESET_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_COUNT;
            cnt   <= '0;
        end else if (counting) begin
            if (last) state <= PH_RUN;
            else      cnt   <= cnt + PW'(1);
        end
    end
endmodule

// File: rtl/prog_entry_detect.sv
module prog_entry_detect
    import prog_entry_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = DEF_RESET_CYCLES,
    parameter int unsigned WINDOW       = DEF_WINDOW,
    parameter int unsigned EDGE_TARGET  = DEF_EDGE_TARGET,
    parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
    parameter logic [15:0] BOOT_VEC     = DEF_BOOT_VEC,
    parameter logic [15:0] USER_VEC     = DEF_USER_VEC
) (
    input  logic        clk,
    input  logic        pin_rst,
    input  logic        sel_pin,
    input  logic        sdata_pin,
    output logic        core_rst,
    output logic        prog_mode,
    output logic [15:0] reset_vector
);
    logic         sel_s;
    logic         sdata_s;
    logic         counting;
    logic         last;
    logic         burst_ok;
    boot_choice_t choice;

    pe_pin_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
        .clk  (clk),
        .rst  (pin_rst),
        .pin  (sel_pin),
        .sync (sel_s)
    );

    pe_pin_sync #(.STAGES(SYNC_STAGES)) u_data_sync (
        .clk  (clk),
        .rst  (pin_rst),
        .pin  (sdata_pin),
        .sync (sdata_s)
    );

    pe_phase_timer #(.RESET_CYCLES(RESET_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (pin_rst),
        .counting (counting),
        .last     (last)
    );

    pe_edge_window #(.WINDOW(WINDOW), .EDGE_TARGET(EDGE_TARGET)) u_window (
        .clk    (clk),
        .rst    (pin_rst),
        .enable (counting),
        .level  (sel_s),
        .hit    (burst_ok)
    );

    always_ff @(posedge clk) begin
        if (pin_rst) begin
            choice.entry <= 1'b0;
            choice.vec   <= USER_VEC;
        end else if (last) begin
            choice <= pick_boot(burst_ok, ~sdata_s, BOOT_VEC, USER_VEC);
        end
    end

    assign core_rst     = pin_rst | counting;
    assign prog_mode    = choice.entry;
    assign reset_vector = choice.vec;
endmodule

// File: rtl/prog_entry_chk.sv
module prog_entry_chk #(
    parameter int unsigned RESET_CYCLES = 4096,
    parameter logic [15:0] BOOT_VEC     = 16'hFE00,
    parameter logic [15:0] USER_VEC     = 16'hFFFE
) (
    input logic        clk,
    input logic        pin_rst,
    input logic        core_rst,
    input logic        prog_mode,
    input logic [15:0] reset_vector
);
    localparam int unsigned KW = $clog2(RESET_CYCLES) + 2;

    logic [KW-1:0] since_rel;

    always_ff @(posedge clk) begin
        if (pin_rst)
            since_rel <= '0;
        else if (since_rel <= KW'(RESET_CYCLES))
            since_rel <= since_rel + KW'(1);
    end

    p_rst_hold_r1: assert property (@(posedge clk) pin_rst |-> core_rst);
    p_rst_flag_r1: assert property (@(posedge clk) pin_rst |=> !prog_mode);

    p_stretch_r2: assert property (@(posedge clk) disable iff (pin_rst)
        (since_rel < KW'(RESET_CYCLES)) |-> core_rst);
    p_release_r2: assert property (@(posedge clk) disable iff (pin_rst)
        $fell(core_rst) |-> (since_rel == KW'(RESET_CYCLES)));

    p_entry_at_release_r3: assert property (@(posedge clk) disable iff (pin_rst)
        $rose(prog_mode) |-> $fell(core_rst));

    p_vector_r7: assert property (@(posedge clk) disable iff (pin_rst)
        !core_rst |-> (reset_vector == (prog_mode ? BOOT_VEC : USER_VEC)));

    p_hold_after_r8: assert property (@(posedge clk) disable iff (pin_rst)
        !core_rst |=> ($stable(prog_mode) && $stable(reset_vector)));
endmodule

bind prog_entry_detect prog_entry_chk #(
    .RESET_CYCLES (RESET_CYCLES),
    .BOOT_VEC     (BOOT_VEC),
    .USER_VEC     (USER_VEC)
) u_chk (
    .clk          (clk),
    .pin_rst      (pin_rst),
    .core_rst     (core_rst),
    .prog_mode    (prog_mode),
    .reset_vector (reset_vector)
);

// File: tb/prog_entry_detect_tb.sv
module prog_entry_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] EXP_BOOT = 16'hFE00;
    localparam logic [15:0] EXP_USER = 16'hFFFE;

    typedef struct packed {
        int   n;
        int   per;
        int   gap;
        logic dat;
        logic exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{33, 2,   2, 1'b0, 1'b1},   // R3 fast burst
        '{32, 2,   2, 1'b0, 1'b0},   // R4 one short
        '{34, 2,   2, 1'b0, 1'b0},   // R4 one extra
        '{33, 4,   4, 1'b0, 1'b1},   // R3 slower burst
        '{33, 2, 193, 1'b0, 1'b1},   // R5 last edge at offset 255
        '{33, 2, 194, 1'b0, 1'b0},   // R5 last edge at offset 256
        '{33, 2,   2, 1'b1, 1'b0},   // R6 data pin high
        '{33, 7,   7, 1'b0, 1'b1},   // R5 span 224
        '{33, 8,   8, 1'b0, 1'b0},   // R5 span 256
        '{ 0, 2,   2, 1'b0, 1'b0},   // R4 no edges
        '{ 1, 2,   2, 1'b0, 1'b0}    // R4 single edge
    };

    logic        clk = 1'b0;
    logic        pin_rst = 1'b1;
    logic        sel_pin = 1'b0;
    logic        sdata_pin = 1'b0;
    logic        core_rst;
    logic        prog_mode;
    logic [15:0] reset_vector;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prog_entry_detect u_dut (
        .clk          (clk),
        .pin_rst      (pin_rst),
        .sel_pin      (sel_pin),
        .sdata_pin    (sdata_pin),
        .core_rst     (core_rst),
        .prog_mode    (prog_mode),
        .reset_vector (reset_vector)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        pin_rst = 1'b1;
        sel_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_rst();
        pin_rst   = 1'b0;
        start_cyc = cyc;
    endtask

    task automatic burst(input int n, input int per, input int gap);
        for (int i = 0; i < n; i++) begin
            int w;
            w = (i == n - 1) ? gap : per;
            sel_pin = 1'b1;
            @(negedge clk);
            sel_pin = 1'b0;
            if (i < n - 1) repeat (((i == n - 2) ? gap : per) - 1) @(negedge clk);
            else           repeat (w - 1) @(negedge clk);
        end
    endtask

    task automatic wait_release();
        while (cyc - start_cyc < 4100) @(negedge clk);
    endtask

    task automatic check_boot(input string tag, input logic exp);
        check(tag, "core_rst", int'(core_rst), 0);
        check(tag, "prog_mode", int'(prog_mode), int'(exp));
        check(tag, "reset_vector", int'(reset_vector), int'(exp ? EXP_BOOT : EXP_USER));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", "core_rst", int'(core_rst), 1);
        check("R1", "prog_mode", int'(prog_mode), 0);
        check("R1", "reset_vector", int'(reset_vector), int'(EXP_USER));

        // Table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            do_reset();
            sdata_pin = VECS[v].dat;
            release_rst();
            repeat (10) @(negedge clk);
            burst(VECS[v].n, VECS[v].per, VECS[v].gap);
            wait_release();
            check_boot($sformatf("R3/R4/R5/R6/R7 vec%0d", v), VECS[v].exp);
            sdata_pin = 1'b0;
        end

        // R2 exact stretch length
        do_reset();
        release_rst();
        repeat (4095) @(negedge clk);
        check("R2", "core_rst after 4095 edges", int'(core_rst), 1);
        @(negedge clk);
        check("R2", "core_rst after 4096 edges", int'(core_rst), 0);

        // R8 entry held against later activity
        do_reset();
        release_rst();
        repeat (10) @(negedge clk);
        burst(33, 2, 2);
        wait_release();
        check_boot("R8 entered", 1'b1);
        sdata_pin = 1'b1;
        burst(33, 2, 2);
        repeat (20) @(negedge clk);
        check_boot("R8 held entry", 1'b1);
        sdata_pin = 1'b0;

        // R8 normal boot ignores later burst
        do_reset();
        release_rst();
        wait_release();
        burst(33, 2, 2);
        repeat (20) @(negedge clk);
        check_boot("R8 held normal", 1'b0);

        // R8 burst straddling the end of the stretch
        do_reset();
        release_rst();
        repeat (4060) @(negedge clk);
        burst(33, 2, 2);
        wait_release();
        check_boot("R8 straddle", 1'b0);

        // R9 reset mid-burst discards edges (20 + 13 would make 33)
        do_reset();
        release_rst();
        repeat (10) @(negedge clk);
        burst(20, 2, 2);
        pin_rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "core_rst during re-reset", int'(core_rst), 1);
        release_rst();
        repeat (10) @(negedge clk);
        burst(13, 2, 2);
        wait_release();
        check_boot("R9 discarded", 1'b0);

        // R9 fresh full burst after mid-phase reset
        do_reset();
        release_rst();
        repeat (10) @(negedge clk);
        burst(20, 2, 2);
        pin_rst = 1'b1;
        repeat (3) @(negedge clk);
        release_rst();
        repeat (2000) @(negedge clk);
        check("R9", "stretch restarted", int'(core_rst), 1);
        burst(33, 2, 2);
        wait_release();
        check_boot("R9 fresh", 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule